// File: doc/BRIEF.md
# Configurable Nibble Ripple Arithmetic Slice

This block is a four-bit add/subtract slice made of identical bit cells. Each cell forms a propagate and a generate term from one bit of each operand. It passes its carry to the cell above it, so the result and the carry settle combinationally from the operands, the carry-in and the add/subtract control. A one-bit dynamic control inverts the second operand. The caller then supplies a carry-in of one to get a two's-complement difference. In that case a carry-out of one means that no borrow occurred.

A small clocked configuration register holds two settings. The first picks where the first cell's carry-in comes from: constant zero, constant one, the fast-carry input from the neighbouring slice, or a spare data input. The second sets which outputs show the final carry: the dedicated carry-out, the general output, both, or neither. Slices cascade to any multiple of four bits. Each slice's dedicated carry-out feeds the fast-carry input of the next slice, and every slice above the first selects the fast-carry source.

Top module: `nib_ripple_slice`

## Requirements
- R1: With the configuration at its reset value, the result is A+B modulo 16 (no carry-in), and the general output stays 0.
- R2: With subtraction off, `res_f` equals (A + B + c) mod 2^W and the final carry equals bit W of that sum, where c is the selected carry-in.
- R3: With `sub_ctl`=1 and a carry-in of 1, `res_f` equals (A − B) mod 2^W, and the final carry is 1 exactly when A ≥ B (unsigned).
- R4: Carry-in select code 2'b00 forces a carry-in of 0, whatever `fast_cin` and `spare_in` are.
- R5: Carry-in select code 2'b01 forces a carry-in of 1.
- R6: Carry-in select code 2'b10 takes the carry-in from `fast_cin`, and `spare_in` has no effect.
- R7: Carry-in select code 2'b11 takes the carry-in from `spare_in`, and `fast_cin` has no effect.
- R8: Route bit 0 lets the final carry onto `fast_cout`, and route bit 1 lets it onto `gen_out`. An output whose bit is 0 drives 0.
- R9: The configuration loads from `cfg_cin_sel`/`cfg_route` only on a rising clock edge with `cfg_we`=1. Otherwise it holds, whatever those inputs do.
- R10: When every cell propagates, the carry-in ripples through all cells to the final carry (A=all ones, B=0, carry-in 1 gives result 0 and carry 1).
- R11: Slices chained from `fast_cout` to `fast_cin` compute correct sums and differences at widths of 4·N bits.
- R12: A synchronous active-high reset sets the configuration to carry-in select 2'b00 and route 2'b01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration register |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration load enable |
| cfg_cin_sel | input | 2 | Carry-in source code to load |
| cfg_route | input | 2 | Carry routing bits to load (bit0 dedicated, bit1 general) |
| op_a | input | W | First operand |
| op_b | input | W | Second operand |
| sub_ctl | input | 1 | 1 = invert the second operand (subtract) |
| spare_in | input | 1 | Spare data input usable as carry-in |
| fast_cin | input | 1 | Fast carry from the neighbouring slice |
| res_f | output | W | Result bits |
| fast_cout | output | 1 | Dedicated carry-out |
| gen_out | output | 1 | General output that can carry the final carry |

## Verification
The bench builds the slice once at its default width of 4, where every carry-in source, route code and borrow case can be reached directly. It also builds a chain of three default slices, forming a 12-bit adder. That chain puts the carry path between slices within reach, including carries that ripple through a whole nibble into the next slice, and multi-slice subtraction with borrow.

// File: rtl/nrs_pkg.sv
package nrs_pkg;
  typedef enum logic [1:0] {
    CIN_ZERO  = 2'b00,
    CIN_ONE   = 2'b01,
    CIN_FAST  = 2'b10,
    CIN_SPARE = 2'b11
  } cin_src_e;

  localparam int ROUTE_DED_BIT = 0;
  localparam int ROUTE_GEN_BIT = 1;

  typedef struct packed {
    cin_src_e   cin_src;
    logic [1:0] route;
  } slice_cfg_t;

  localparam slice_cfg_t CFG_RESET = '{cin_src: CIN_ZERO, route: 2'b01};
endpackage

// File: rtl/nrs_bit_cell.sv
module nrs_bit_cell (
  input  logic a_i,
  input  logic b_i,
  input  logic c_i,
  output logic s_o,
  output logic c_o,
  output logic p_o
);
  logic gen;
  assign p_o = a_i ^ b_i;
  assign gen = a_i & b_i;
  assign s_o = p_o ^ c_i;
  assign c_o = gen | (p_o & c_i);
endmodule

// File: rtl/nrs_carry_chain.sv
module nrs_carry_chain #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         ci,
  output logic [W-1:0] s_o,
  output logic         co
);
  logic [W:0]   carry;
  logic [W-1:0] prop;

  assign carry[0] = ci;

  for (genvar i = 0; i < W; i++) begin : g_cell
    nrs_bit_cell u_cell (
      .a_i (a_i[i]),
      .b_i (b_i[i]),
      .c_i (carry[i]),
      .s_o (s_o[i]),
      .c_o (carry[i+1]),
      .p_o (prop[i])
    );
  end

  assign co = carry[W];

  // R2: gate-level ripple matches arithmetic sum
  p_sum_matches_r2: assert property (@(posedge clk) disable iff (rst)
    {co, s_o} == ({1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, ci}));

  // R10: full propagate passes carry-in to carry-out
  p_full_ripple_r10: assert property (@(posedge clk) disable iff (rst)
    (&prop) |-> (co == ci));
endmodule

// File: rtl/nrs_cin_mux.sv
module nrs_cin_mux
  import nrs_pkg::*;
(
  input  cin_src_e sel,
  input  logic     fast_i,
  input  logic     spare_i,
  output logic     cin_o
);
  always_comb begin
    unique case (sel)
      CIN_ZERO:  cin_o = 1'b0;
      CIN_ONE:   cin_o = 1'b1;
      CIN_FAST:  cin_o = fast_i;
      CIN_SPARE: cin_o = spare_i;
      default:   cin_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/nrs_cfg_reg.sv
module nrs_cfg_reg
  import nrs_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       we,
  input  slice_cfg_t wdata,
  output slice_cfg_t cfg
);
  always_ff @(posedge clk) begin
    if (rst)     cfg <= CFG_RESET;
    else if (we) cfg <= wdata;
  end

  // R12: reset returns configuration to its default
  p_reset_default_r12: assert property (@(posedge clk)
    rst |=> (cfg == CFG_RESET));

  // R9: without enable, configuration holds
  p_hold_cfg_r9: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(cfg));

  // R9: with enable, the written value appears next cycle
  p_load_cfg_r9: assert property (@(posedge clk) disable iff (rst)
    we |=> (cfg == $past(wdata)));
endmodule

// File: rtl/nib_ripple_slice.sv
module nib_ripple_slice
  import nrs_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cfg_we,
  input  logic [1:0]   cfg_cin_sel,
  input  logic [1:0]   cfg_route,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic         sub_ctl,
  input  logic         spare_in,
  input  logic         fast_cin,
  output logic [W-1:0] res_f,
  output logic         fast_cout,
  output logic         gen_out
);
  slice_cfg_t   cfg_q;
  slice_cfg_t   cfg_d;
  logic         ripple_in;
  logic         ripple_out;
  logic [W-1:0] b_eff;

  assign cfg_d.cin_src = cin_src_e'(cfg_cin_sel);
  assign cfg_d.route   = cfg_route;

  nrs_cfg_reg u_cfg (
    .clk   (clk),
    .rst   (rst),
    .we    (cfg_we),
    .wdata (cfg_d),
    .cfg   (cfg_q)
  );

  nrs_cin_mux u_cin (
    .sel     (cfg_q.cin_src),
    .fast_i  (fast_cin),
    .spare_i (spare_in),
    .cin_o   (ripple_in)
  );

  assign b_eff = op_b ^ {W{sub_ctl}};

  nrs_carry_chain #(.W(W)) u_chain (
    .clk  (clk),
    .rst  (rst),
    .a_i  (op_a),
    .b_i  (b_eff),
    .ci   (ripple_in),
    .s_o  (res_f),
    .co   (ripple_out)
  );

  assign fast_cout = cfg_q.route[ROUTE_DED_BIT] & ripple_out;
  assign gen_out   = cfg_q.route[ROUTE_GEN_BIT] & ripple_out;

  // R8: unrouted outputs stay low
  p_ded_off_r8: assert property (@(posedge clk) disable iff (rst)
    !cfg_q.route[ROUTE_DED_BIT] |-> !fast_cout);
  p_gen_off_r8: assert property (@(posedge clk) disable iff (rst)
    !cfg_q.route[ROUTE_GEN_BIT] |-> !gen_out);
  p_both_agree_r8: assert property (@(posedge clk) disable iff (rst)
    (&cfg_q.route) |-> (fast_cout == gen_out));

  // R4 / R5: constant carry-in sources
  p_cin_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (cfg_q.cin_src == CIN_ZERO) |-> !ripple_in);
  p_cin_one_r5: assert property (@(posedge clk) disable iff (rst)
    (cfg_q.cin_src == CIN_ONE) |-> ripple_in);

  // R3: subtract with carry-in 1 yields the difference
  p_sub_diff_r3: assert property (@(posedge clk) disable iff (rst)
    (sub_ctl && ripple_in) |-> (res_f == W'(op_a - op_b)));
endmodule

// File: tb/nib_ripple_slice_bench.sv
module nib_ripple_slice_bench;
  localparam int W  = 4;
  localparam int NS = 3;
  localparam int CW = W * NS;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic         cfg_we = 1'b0;
  logic [1:0]   cfg_cin_sel = 2'b00;
  logic [1:0]   cfg_route = 2'b00;
  logic [W-1:0] op_a = '0;
  logic [W-1:0] op_b = '0;
  logic         sub_ctl = 1'b0;
  logic         spare_in = 1'b0;
  logic         fast_cin = 1'b0;
  logic [W-1:0] res_f;
  logic         fast_cout;
  logic         gen_out;

  nib_ripple_slice #(.W(W)) u_nib_ripple_slice (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_cin_sel(cfg_cin_sel),
    .cfg_route(cfg_route), .op_a(op_a), .op_b(op_b), .sub_ctl(sub_ctl),
    .spare_in(spare_in), .fast_cin(fast_cin), .res_f(res_f),
    .fast_cout(fast_cout), .gen_out(gen_out)
  );

  // chained build
  logic [CW-1:0] ch_a = '0;
  logic [CW-1:0] ch_b = '0;
  logic          ch_sub = 1'b0;
  logic [1:0]    ch_sel0 = 2'b00;
  logic [CW-1:0] ch_f;
  logic [NS-1:0] ch_co;
  logic [NS-1:0] ch_go;
  logic [NS-1:0] ch_ci;
  assign ch_ci = {ch_co[NS-2:0], 1'b0};

  for (genvar k = 0; k < NS; k++) begin : g_chain
    nib_ripple_slice #(.W(W)) u_link (
      .clk(clk), .rst(rst), .cfg_we(cfg_we),
      .cfg_cin_sel((k == 0) ? ch_sel0 : 2'b10),
      .cfg_route(2'b01), .op_a(ch_a[k*W +: W]), .op_b(ch_b[k*W +: W]),
      .sub_ctl(ch_sub), .spare_in(1'b0), .fast_cin(ch_ci[k]),
      .res_f(ch_f[k*W +: W]), .fast_cout(ch_co[k]), .gen_out(ch_go[k])
    );
  end

  int n_chk = 0;
  int n_err = 0;

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_cfg(logic [1:0] sel, logic [1:0] route);
    @(negedge clk);
    cfg_cin_sel = sel; cfg_route = route; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic apply(int a, int b, logic s);
    op_a = W'(a); op_b = W'(b); sub_ctl = s;
    #2;
  endtask

  task automatic t_reset_state();
    fast_cin = 1'b1; spare_in = 1'b1;
    apply(3, 4, 1'b0);
    chk("R1 sum", res_f, 7);
    chk("R12 no carry-in after reset", res_f, 7);
    apply(12, 5, 1'b0);
    chk("R1 sum wrap", res_f, 1);
    chk("R12 route dedicated", fast_cout, 1);
    chk("R1 general output low", gen_out, 0);
  endtask

  task automatic t_add_patterns();
    write_cfg(2'b00, 2'b11);
    for (int a = 0; a < 16; a += 5) begin
      for (int b = 1; b < 16; b += 6) begin
        apply(a, b, 1'b0);
        chk("R2 sum", res_f, (a + b) % 16);
        chk("R2 carry", fast_cout, (a + b) / 16);
        chk("R8 both routes agree", gen_out, (a + b) / 16);
      end
    end
  endtask

  task automatic t_cin_sources();
    write_cfg(2'b00, 2'b01);
    fast_cin = 1'b1; spare_in = 1'b1;
    apply(5, 6, 1'b0);
    chk("R4 const zero ignores inputs", res_f, 11);
    write_cfg(2'b01, 2'b01);
    fast_cin = 1'b0; spare_in = 1'b0;
    apply(5, 6, 1'b0);
    chk("R5 const one", res_f, 12);
    write_cfg(2'b10, 2'b01);
    fast_cin = 1'b0; spare_in = 1'b1;
    apply(5, 6, 1'b0);
    chk("R6 fast low, spare ignored", res_f, 11);
    fast_cin = 1'b1; spare_in = 1'b0;
    apply(5, 6, 1'b0);
    chk("R6 fast high", res_f, 12);
    write_cfg(2'b11, 2'b01);
    fast_cin = 1'b1; spare_in = 1'b0;
    apply(5, 6, 1'b0);
    chk("R7 spare low, fast ignored", res_f, 11);
    spare_in = 1'b1; fast_cin = 1'b0;
    apply(5, 6, 1'b0);
    chk("R7 spare high", res_f, 12);
  endtask

  task automatic t_subtract();
    write_cfg(2'b01, 2'b01);
    apply(9, 3, 1'b1);
    chk("R3 diff", res_f, 6);
    chk("R3 no borrow", fast_cout, 1);
    apply(3, 9, 1'b1);
    chk("R3 diff wrap", res_f, 10);
    chk("R3 borrow", fast_cout, 0);
    apply(7, 7, 1'b1);
    chk("R3 equal diff", res_f, 0);
    chk("R3 equal no borrow", fast_cout, 1);
  endtask

  task automatic t_routes();
    write_cfg(2'b01, 2'b00);
    apply(15, 1, 1'b0);
    chk("R8 dedicated off", fast_cout, 0);
    chk("R8 general off", gen_out, 0);
    write_cfg(2'b01, 2'b10);
    apply(15, 1, 1'b0);
    chk("R8 dedicated off in general-only", fast_cout, 0);
    chk("R8 general carries carry", gen_out, 1);
  endtask

  task automatic t_hold();
    write_cfg(2'b00, 2'b01);
    @(negedge clk);
    cfg_cin_sel = 2'b01; cfg_route = 2'b00;
    repeat (2) @(negedge clk);
    apply(15, 2, 1'b0);
    chk("R9 carry-in source held", res_f, 1);
    chk("R9 route held", fast_cout, 1);
  endtask

  task automatic t_full_ripple();
    write_cfg(2'b01, 2'b01);
    apply(15, 0, 1'b0);
    chk("R10 ripple result", res_f, 0);
    chk("R10 ripple carry", fast_cout, 1);
  endtask

  task automatic t_chain();
    logic [CW:0] exp;
    @(negedge clk);
    ch_sel0 = 2'b00; cfg_we = 1'b1;
    cfg_cin_sel = 2'b00; cfg_route = 2'b01;
    @(negedge clk);
    cfg_we = 1'b0;
    ch_sub = 1'b0;
    ch_a = 12'hFFF; ch_b = 12'h001; #2;
    chk("R11 chain full ripple sum", ch_f, 0);
    chk("R11 chain carry", ch_co[NS-1], 1);
    ch_a = 12'h5A7; ch_b = 12'h3C9; #2;
    exp = {1'b0, ch_a} + {1'b0, ch_b};
    chk("R11 chain sum", ch_f, int'(exp[CW-1:0]));
    chk("R11 chain carry", ch_co[NS-1], int'(exp[CW]));
    @(negedge clk);
    ch_sel0 = 2'b01; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
    ch_sub = 1'b1;
    ch_a = 12'h100; ch_b = 12'h001; #2;
    chk("R11 chain diff", ch_f, 12'h0FF);
    chk("R11 chain no borrow", ch_co[NS-1], 1);
    ch_a = 12'h010; ch_b = 12'h200; #2;
    chk("R11 chain diff wrap", ch_f, 12'hE10);
    chk("R11 chain borrow", ch_co[NS-1], 0);
  endtask

  task automatic t_reset_again();
    write_cfg(2'b01, 2'b10);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    fast_cin = 1'b1; spare_in = 1'b1;
    apply(15, 1, 1'b0);
    chk("R12 carry-in zero after reset", res_f, 0);
    chk("R12 dedicated on after reset", fast_cout, 1);
    chk("R12 general off after reset", gen_out, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset_state();
    t_add_patterns();
    t_cin_sources();
    t_subtract();
    t_routes();
    t_hold();
    t_full_ripple();
    t_chain();
    t_reset_again();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #2000000;
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule